// File: doc/BRIEF.md
# Step-Down Rail Sequencer and Processor Reset Generator

This block turns one shared enable request into the enables of three step-down regulators and produces an active-low processor reset. The regulators are released only after the internal bias has been ready for a fixed number of ticks. In sequenced mode the rails come up one at a time in a parameterised order, and each rail waits until the previous one has finished its soft-start and reports power-good. When the request is withdrawn the rails go down in the reverse order, one every fixed interval. In simultaneous mode all three enables move together.

The reset output follows the feedback-OK flag of rail 0, which is the rail the processor core runs from. Reset is released only after that rail has been good for a long, fixed delay. A short dip of the flag is filtered out. A supply undervoltage shuts everything down and asserts reset at once. A thermal shutdown removes all rails, and when it clears the full bias delay and power-up sequence run again. Every delay counts ticks of one clock-enable, so the whole block can be run at a reduced scale.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, no rail is enabled until `sys_ok` is high and `therm_sd` is low for BIAS_TICKS consecutive ticks. The first enable appears on the tick after that, provided `en_all` is high.
- R2: With SEQUENCED=1, rails are enabled one at a time. Nibble k of PWR_ORDER (bits 4k+3 down to 4k) names the k-th rail to come up, and bit i of `rail_en` enables rail i. Each following rail is enabled SS_TICKS+1 ticks after the previous one.
- R3: A following rail is enabled only once `pgood` of the most recently enabled rail is high. While it is low, the sequence holds the rails it already has.
- R4: `ss_active` is high during the SS_TICKS ticks that follow each power-up enable, and low once all rails are up.
- R5: When `en_all` falls, the most recently enabled rail is disabled on the next tick. The remaining rails follow in reverse power-up order, one every DOWN_TICKS ticks. No rail is enabled while `en_all` is low.
- R6: With SEQUENCED=0, all rails are enabled in the same cycle and disabled in the same cycle.
- R7: `rst_out_n` is low out of reset. It goes high only after rail 0 has been enabled with `fb1_ok` high and `sys_ok` high for RST_TICKS consecutive ticks.
- R8: Once reset is released, a low level on `fb1_ok` lasting fewer than BLANK_TICKS ticks has no effect. BLANK_TICKS consecutive low ticks assert reset.
- R9: Reset is asserted on the tick after rail 0 is disabled.
- R10: When `sys_ok` is low, all rails are disabled and reset is asserted in the same cycle.
- R11: When `therm_sd` is high, all rails are disabled on the next cycle. When it clears, the bias delay of R1 and the power-up sequence of R2 repeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_all | input | 1 | Shared enable request for the three rails |
| sys_ok | input | 1 | System supply above its undervoltage threshold |
| therm_sd | input | 1 | Die over-temperature shutdown |
| pgood | input | NRAIL | Per-rail power-good flags |
| fb1_ok | input | 1 | Feedback of rail 0 above its reset threshold |
| rail_en | output | NRAIL | Per-rail regulator enables |
| ss_active | output | 1 | A soft-start ramp is in progress |
| rst_out_n | output | 1 | Active-low processor reset |

## Verification
The riskiest overlap is a shutdown landing while the reset release counter is part-way through its count. The bench provokes it by stalling the sequence on a blocked power-good. This lets rail 0 come up and start the release count, and then thermal shutdown is raised in the middle of that count. The bench judges the event stream: all rails must drop in one cycle, reset must never release, and after the fault clears the full bias delay and ordered ramp must run again. A second overlap is undervoltage, where the rail shutdown and the reset assertion must show up in the same cycle, with no window in between.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_UP   = 2'd1,
    SQ_ON   = 2'd2,
    SQ_DOWN = 2'd3
  } sq_state_e;

  // bits needed to hold values 0..maxv
  function automatic int cnt_width(input int maxv);
    int w;
    w = $clog2(maxv + 1);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // rail index of the k-th step of the power-up order (one nibble per step)
  function automatic logic [3:0] order_idx(input logic [31:0] order, input int k);
    return order[4*k +: 4];
  endfunction

endpackage

// File: rtl/rail_seq_tick.sv
`timescale 1ns/1ps
module rail_seq_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = rail_seq_pkg::cnt_width(DIV - 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/rail_seq_bias.sv
`timescale 1ns/1ps
module rail_seq_bias #(
  parameter int BIAS_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ready,
  output logic regs_ok
);
  localparam int CW = rail_seq_pkg::cnt_width(BIAS_TICKS);
  localparam logic [CW-1:0] LAST = CW'(BIAS_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      regs_ok <= 1'b0;
    end else if (!ready) begin
      cnt     <= '0;
      regs_ok <= 1'b0;
    end else if (tick && !regs_ok) begin
      if (cnt == LAST) regs_ok <= 1'b1;
      else             cnt     <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rail_seq_fsm.sv
`timescale 1ns/1ps
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int          NRAIL      = 3,
  parameter bit          SEQUENCED  = 1'b1,
  parameter logic [31:0] PWR_ORDER  = 32'h0000_0210,
  parameter int          SS_TICKS   = 5200,
  parameter int          DOWN_TICKS = 5200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_ok,
  input  logic             en_all,
  input  logic [NRAIL-1:0] pgood,
  output logic [NRAIL-1:0] rail_en,
  output logic             ss_active
);
  localparam int CW = cnt_width(NRAIL);
  localparam int TW = cnt_width(max2(SS_TICKS, DOWN_TICKS));
  localparam int IW = (NRAIL > 1) ? $clog2(NRAIL) : 1;
  localparam logic [TW-1:0] SS_END = TW'(SS_TICKS);
  localparam logic [TW-1:0] DN_END = TW'(DOWN_TICKS - 1);
  localparam logic [CW-1:0] FULL   = CW'(NRAIL);
  localparam logic [CW-1:0] UP_FIRST = SEQUENCED ? CW'(1) : CW'(NRAIL);

  sq_state_e       st;
  logic [CW-1:0]   n_on;
  logic [TW-1:0]   tmr;
  logic [NRAIL-1:0] en_mask;
  logic            newest_pg;
  logic            pg_ok;
  logic [CW-1:0]   dn_next;
  logic [IW-1:0]   idx;

  // decode the count of active steps into per-rail enables
  always_comb begin
    en_mask   = '0;
    newest_pg = 1'b0;
    idx       = '0;
    for (int k = 0; k < NRAIL; k++) begin
      idx = IW'(order_idx(PWR_ORDER, k));
      if (k < int'(n_on))      en_mask[idx] = 1'b1;
      if (k + 1 == int'(n_on)) newest_pg    = pgood[idx];
    end
  end

  assign pg_ok   = SEQUENCED ? newest_pg : (&pgood);
  assign dn_next = SEQUENCED ? (n_on - CW'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_OFF;
      n_on <= '0;
      tmr  <= '0;
    end else if (!go_ok) begin
      st   <= SQ_OFF;
      n_on <= '0;
      tmr  <= '0;
    end else begin
      case (st)
        SQ_OFF: begin
          if (en_all) begin
            n_on <= UP_FIRST;
            tmr  <= '0;
            st   <= SQ_UP;
          end
        end
        SQ_UP: begin
          if (!en_all) begin
            n_on <= dn_next;
            tmr  <= '0;
            st   <= (dn_next == '0) ? SQ_OFF : SQ_DOWN;
          end else if (tmr == SS_END) begin
            if (pg_ok) begin
              if (n_on == FULL) begin
                st <= SQ_ON;
              end else begin
                n_on <= n_on + CW'(1);
                tmr  <= '0;
              end
            end
          end else if (tick) begin
            tmr <= tmr + TW'(1);
          end
        end
        SQ_ON: begin
          if (!en_all) begin
            n_on <= dn_next;
            tmr  <= '0;
            st   <= (dn_next == '0) ? SQ_OFF : SQ_DOWN;
          end
        end
        default: begin
          if (tick) begin
            if (tmr == DN_END) begin
              n_on <= dn_next;
              tmr  <= '0;
              if (dn_next == '0) st <= SQ_OFF;
            end else begin
              tmr <= tmr + TW'(1);
            end
          end
        end
      endcase
    end
  end

  assign rail_en   = en_mask;
  assign ss_active = (st == SQ_UP) && (tmr != SS_END);
endmodule

// File: rtl/rail_seq_rst.sv
`timescale 1ns/1ps
module rail_seq_rst #(
  parameter int RST_TICKS   = 400000,
  parameter int BLANK_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sys_ok,
  input  logic rail_on,
  input  logic fb_ok,
  output logic rst_out_n
);
  localparam int CW = rail_seq_pkg::cnt_width(rail_seq_pkg::max2(RST_TICKS, BLANK_TICKS));
  localparam logic [CW-1:0] REL_END = CW'(RST_TICKS - 1);
  localparam logic [CW-1:0] BLK_END = CW'(BLANK_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel <= 1'b0;
      cnt <= '0;
    end else if (!rel) begin
      if (sys_ok && rail_on && fb_ok) begin
        if (tick) begin
          if (cnt == REL_END) begin
            rel <= 1'b1;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end else begin
        cnt <= '0;
      end
    end else if (!sys_ok || !rail_on) begin
      rel <= 1'b0;
      cnt <= '0;
    end else if (!fb_ok) begin
      if (tick) begin
        if (cnt == BLK_END) begin
          rel <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end else begin
      cnt <= '0;
    end
  end

  assign rst_out_n = rel;
endmodule

// File: rtl/rail_seq_top.sv
`timescale 1ns/1ps
module rail_seq_top #(
  parameter int          NRAIL       = 3,
  parameter bit          SEQUENCED   = 1'b1,
  parameter logic [31:0] PWR_ORDER   = 32'h0000_0210,
  parameter int          TICK_DIV    = 1,
  parameter int          BIAS_TICKS  = 64,
  parameter int          SS_TICKS    = 5200,
  parameter int          DOWN_TICKS  = 5200,
  parameter int          RST_TICKS   = 400000,
  parameter int          BLANK_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_all,
  input  logic             sys_ok,
  input  logic             therm_sd,
  input  logic [NRAIL-1:0] pgood,
  input  logic             fb1_ok,
  output logic [NRAIL-1:0] rail_en,
  output logic             ss_active,
  output logic             rst_out_n
);
  logic tick;
  logic bias_rdy;
  logic regs_ok;
  logic go_ok;

  assign bias_rdy = sys_ok & ~therm_sd;
  assign go_ok    = bias_rdy & regs_ok;

  rail_seq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rail_seq_bias #(.BIAS_TICKS(BIAS_TICKS)) u_bias (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ready(bias_rdy), .regs_ok(regs_ok)
  );

  rail_seq_fsm #(
    .NRAIL(NRAIL), .SEQUENCED(SEQUENCED), .PWR_ORDER(PWR_ORDER),
    .SS_TICKS(SS_TICKS), .DOWN_TICKS(DOWN_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go_ok(go_ok), .en_all(en_all),
    .pgood(pgood), .rail_en(rail_en), .ss_active(ss_active)
  );

  rail_seq_rst #(.RST_TICKS(RST_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sys_ok(sys_ok),
    .rail_on(rail_en[0]), .fb_ok(fb1_ok), .rst_out_n(rst_out_n)
  );
endmodule

// File: rtl/rail_seq_chk.sv
`timescale 1ns/1ps
module rail_seq_chk #(
  parameter int NRAIL       = 3,
  parameter bit SEQUENCED   = 1'b1,
  parameter int RST_TICKS   = 400000,
  parameter int BLANK_TICKS = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_all,
  input logic             sys_ok,
  input logic             therm_sd,
  input logic             fb1_ok,
  input logic             regs_ok,
  input logic [NRAIL-1:0] rail_en,
  input logic             rst_out_n
);
  localparam int HW = rail_seq_pkg::cnt_width(RST_TICKS);
  localparam int LW = rail_seq_pkg::cnt_width(BLANK_TICKS);

  logic [HW-1:0] hirun;
  logic [LW-1:0] lowrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hirun  <= '0;
      lowrun <= '0;
    end else begin
      if (sys_ok && rail_en[0] && fb1_ok) begin
        if (hirun != HW'(RST_TICKS)) hirun <= hirun + HW'(1);
      end else begin
        hirun <= '0;
      end
      if (!fb1_ok) begin
        if (lowrun != LW'(BLANK_TICKS)) lowrun <= lowrun + LW'(1);
      end else begin
        lowrun <= '0;
      end
    end
  end

  AST_BIAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en != '0) && ($past(rail_en) == '0) |-> $past(regs_ok)); // R1

  AST_UV_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ok |=> (rail_en == '0) && !rst_out_n); // R10

  AST_THERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    therm_sd |=> (rail_en == '0)); // R11

  AST_NO_RISE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_all) |-> ((rail_en & ~$past(rail_en)) == '0)); // R5

  AST_RELEASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (hirun >= HW'(RST_TICKS))); // R7

  AST_BLANK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) && $past(sys_ok) && $past(rail_en[0]) |-> (lowrun >= LW'(BLANK_TICKS))); // R8

  generate
    if (SEQUENCED) begin : g_seq
      AST_ONE_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en & ~$past(rail_en)) <= 1); // R2
    end else begin : g_sim
      AST_SIM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en == '0) || (&rail_en)); // R6
    end
  endgenerate
endmodule

bind rail_seq_top rail_seq_chk #(
  .NRAIL(NRAIL), .SEQUENCED(SEQUENCED),
  .RST_TICKS(RST_TICKS), .BLANK_TICKS(BLANK_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_all(en_all), .sys_ok(sys_ok),
  .therm_sd(therm_sd), .fb1_ok(fb1_ok), .regs_ok(regs_ok),
  .rail_en(rail_en), .rst_out_n(rst_out_n)
);

// File: tb/rail_seq_top_tb.sv
`timescale 1ns/1ps
module rail_seq_top_tb;
  localparam int BIAS = 64;
  localparam int SS   = 20;
  localparam int DN   = 10;
  localparam int RSTD = 200;
  localparam int BLK  = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic en_all, sys_ok, therm;
  logic [2:0] pg_block;
  logic fb_dip;

  logic [2:0] rail_en, s_rail_en;
  logic ss_act, s_ss_act, rst_o, s_rst_o;
  logic [2:0] pgood, s_pgood;
  logic fb, s_fb;

  assign pgood   = rail_en & ~pg_block;
  assign fb      = rail_en[0] & ~fb_dip;
  assign s_pgood = s_rail_en;
  assign s_fb    = s_rail_en[0];

  always #2 clk = ~clk;

  rail_seq_top #(
    .NRAIL(3), .SEQUENCED(1'b1), .PWR_ORDER(32'h0000_0102), .TICK_DIV(1),
    .BIAS_TICKS(BIAS), .SS_TICKS(SS), .DOWN_TICKS(DN), .RST_TICKS(RSTD), .BLANK_TICKS(BLK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en_all(en_all), .sys_ok(sys_ok), .therm_sd(therm),
    .pgood(pgood), .fb1_ok(fb), .rail_en(rail_en), .ss_active(ss_act), .rst_out_n(rst_o)
  );

  rail_seq_top #(
    .NRAIL(3), .SEQUENCED(1'b0), .PWR_ORDER(32'h0000_0210), .TICK_DIV(1),
    .BIAS_TICKS(BIAS), .SS_TICKS(SS), .DOWN_TICKS(DN), .RST_TICKS(RSTD), .BLANK_TICKS(BLK)
  ) u_dut_sim (
    .clk(clk), .rst_n(rst_n), .en_all(en_all), .sys_ok(sys_ok), .therm_sd(therm),
    .pgood(s_pgood), .fb1_ok(s_fb), .rail_en(s_rail_en), .ss_active(s_ss_act), .rst_out_n(s_rst_o)
  );

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: expected {rst_out_n, rail_en} changes with a cycle window
  logic [3:0] q_v[$];
  int         q_lo[$];
  int         q_hi[$];
  string      q_tag[$];

  task automatic expect_v(input logic [3:0] v, input int at, input int tol, input string tag);
    q_v.push_back(v);
    q_lo.push_back(at - tol);
    q_hi.push_back(at + tol);
    q_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  logic [3:0] prev_v;

  always @(negedge clk) begin
    if (started && !finished) begin
      logic [3:0] cur;
      cur = {rst_o, rail_en};
      if (cur !== prev_v) begin
        tests++;
        if (q_v.size() == 0) begin
          fails++;
          $display("FAIL unexpected change at cycle %0d: actual %b expected no change", cyc, cur);
        end else begin
          logic [3:0] ev;
          int lo, hi;
          string tg;
          ev = q_v.pop_front();
          lo = q_lo.pop_front();
          hi = q_hi.pop_front();
          tg = q_tag.pop_front();
          if (cur !== ev || cyc < lo || cyc > hi) begin
            fails++;
            $display("FAIL %s: actual %b at cycle %0d expected %b in cycles %0d..%0d",
                     tg, cur, cyc, ev, lo, hi);
          end
        end
        prev_v = cur;
      end
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; en_all = 1'b0; sys_ok = 1'b0; therm = 1'b0;
    pg_block = 3'b000; fb_dip = 1'b0;
    repeat (5) @(negedge clk);
    check(rail_en == 3'b000 && s_rail_en == 3'b000, "R7", "rails in reset", int'(rail_en), 0);
    check(rst_o == 1'b0 && ss_act == 1'b0, "R7", "reset out during reset", int'(rst_o), 0);
    rst_n = 1'b1;
    prev_v = {rst_o, rail_en};
    started = 1'b1;
    repeat (3) @(negedge clk);

    // power-up, order rail2, rail0, rail1
    c = cyc;
    sys_ok = 1'b1; en_all = 1'b1;
    expect_v(4'b0100, c + BIAS + 1, 1, "R1 first rail after bias delay");
    expect_v(4'b0101, c + BIAS + 1 + (SS + 1), 1, "R2 second rail in order");
    expect_v(4'b0111, c + BIAS + 1 + 2 * (SS + 1), 1, "R2 third rail in order");
    expect_v(4'b1111, c + BIAS + 1 + (SS + 1) + RSTD, 1, "R7 reset release delay");
    wait_until(c + BIAS - 1);
    check(s_rail_en == 3'b000, "R1", "simultaneous rails before bias delay", int'(s_rail_en), 0);
    wait_until(c + BIAS + 2);
    check(s_rail_en == 3'b111, "R6", "simultaneous rails together", int'(s_rail_en), 7);
    wait_until(c + BIAS + 6);
    check(ss_act == 1'b1, "R4", "soft-start active on first ramp", int'(ss_act), 1);
    wait_until(c + BIAS + 1 + (SS + 1) + 5);
    check(ss_act == 1'b1, "R4", "soft-start active on second ramp", int'(ss_act), 1);
    wait_until(c + BIAS + 1 + 3 * (SS + 1) + 3);
    check(ss_act == 1'b0 && s_ss_act == 1'b0, "R4", "soft-start idle when all up", int'(ss_act), 0);
    wait_until(c + 300);

    // short dip on the feedback flag is filtered
    c = cyc;
    fb_dip = 1'b1;
    wait_until(c + BLK - 1);
    fb_dip = 1'b0;
    wait_until(c + 40);
    check({rst_o, rail_en} == 4'b1111, "R8", "short feedback dip ignored", int'({rst_o, rail_en}), 15);

    // long dip asserts reset, recovery releases it again
    c = cyc;
    fb_dip = 1'b1;
    expect_v(4'b0111, c + BLK, 1, "R8 reset after blanking window");
    wait_until(c + 20);
    fb_dip = 1'b0;
    expect_v(4'b1111, c + 20 + RSTD, 1, "R7 release after recovery");
    wait_until(c + 20 + RSTD + 20);

    // reverse-order power-down
    c = cyc;
    en_all = 1'b0;
    expect_v(4'b1101, c + 1, 1, "R5 last rail off first");
    expect_v(4'b1100, c + 1 + DN, 1, "R5 middle rail off");
    expect_v(4'b0100, c + 2 + DN, 1, "R9 reset after rail 0 off");
    expect_v(4'b0000, c + 1 + 2 * DN, 1, "R5 first rail off last");
    wait_until(c + 4);
    check(s_rail_en == 3'b000, "R6", "simultaneous rails off together", int'(s_rail_en), 0);
    wait_until(c + 40);

    // restart with rail 0 power-good held low: the sequence stalls
    pg_block = 3'b001;
    c = cyc;
    en_all = 1'b1;
    expect_v(4'b0100, c + 1, 1, "R2 restart first rail");
    expect_v(4'b0101, c + 1 + (SS + 1), 1, "R2 restart second rail");
    wait_until(c + 80);
    check({rst_o, rail_en} == 4'b0101, "R3", "sequence stalls without power-good", int'({rst_o, rail_en}), 5);

    // thermal shutdown during the stall and the reset release count
    c = cyc;
    therm = 1'b1;
    expect_v(4'b0000, c + 1, 1, "R11 thermal removes all rails");
    wait_until(c + 3);
    check(s_rail_en == 3'b000, "R11", "simultaneous rails off on thermal", int'(s_rail_en), 0);
    wait_until(c + 10);
    therm = 1'b0;
    pg_block = 3'b000;
    c = cyc;
    expect_v(4'b0100, c + BIAS + 1, 1, "R11 restart after bias delay");
    expect_v(4'b0101, c + BIAS + 1 + (SS + 1), 1, "R11 restart second rail");
    expect_v(4'b0111, c + BIAS + 1 + 2 * (SS + 1), 1, "R11 restart third rail");
    expect_v(4'b1111, c + BIAS + 1 + (SS + 1) + RSTD, 1, "R11 reset release after restart");
    wait_until(c + 300);

    // undervoltage: rails and reset in the same cycle
    c = cyc;
    sys_ok = 1'b0;
    expect_v(4'b0000, c + 1, 0, "R10 undervoltage shutdown");
    wait_until(c + 5);
    check(s_rail_en == 3'b000 && s_rst_o == 1'b0, "R10", "simultaneous part undervoltage", int'(s_rail_en), 0);
    wait_until(c + 20);

    check(q_v.size() == 0, "R5", "all expected events seen", q_v.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL R1 watchdog expired: actual %0d expected 0 pending", q_v.size());
      summary();
      $finish;
    end
  end
endmodule